// File: doc/BRIEF.md
# Tracking Counter Status Generator

This block is the digital bookkeeping half of a tracking position converter. Each cycle it may receive a one-cycle strobe asking for a single step up or a single step down. Each strobe stands for one least-significant-bit movement of the sensed angle. An N-bit up/down count holds the position. Each applied step raises a stretched BUSY pulse. A direction flag shows which way the input last moved. A ripple clock marks every pass of the count through its full-scale wrap, in either direction. The count is exposed for a downstream output latch.

Each accepted request runs through three stages, one clock apart. In the first, the direction flag is updated. In the second, the ripple clock is raised if the step crosses the wrap point. In the third, the count changes and BUSY rises. The direction therefore settles two cycles ahead of BUSY, and the ripple clock one cycle ahead. While a pulse is in flight, one further step can wait in a single-entry slot.

The ripple clock normally drops when the next step is taken, which is two cycles before that step's BUSY rises. If the direction reverses while the ripple clock is high, the drop is put off. The direction must then stay unchanged across two consecutive step-driven BUSY rising edges, and the ripple clock falls one cycle after the second of them. A latch-hold input freezes nothing inside the block. Releasing it requests one extra BUSY pulse that tells the latch to refresh, with no step attached. RC_MIN_CYC is expected to be smaller than BUSY_CYC.

Top module: `track_status_gen`

## Requirements
- R1: After reset the count is 0, BUSY and the ripple clock are low, and the direction output is 1 (1 means up, 0 means down).
- R2: An applied up step adds 1 to the count and a down step subtracts 1, modulo 2^CNT_W. The count changes only on the edge where BUSY rises. A full revolution of 2^CNT_W up steps returns the count to its start value.
- R3: Every applied step or refresh produces exactly one BUSY pulse that is high for exactly BUSY_CYC cycles.
- R4: A strobe sampled at edge e, with the block idle, updates the direction output at edge e+1. The count and BUSY follow at edge e+3, so direction changes only while BUSY is low and stays low for the next cycle.
- R5: A step from all ones up to zero, or from zero down to all ones, raises the ripple clock at edge e+2, one cycle before that step's BUSY rises.
- R6: The ripple clock stays high for at least RC_MIN_CYC cycles. With no direction reversal, it falls at the edge where the next step is taken (e+1 of that step).
- R7: If a step taken while the ripple clock is high reverses the direction, the ripple clock stays high. It falls one cycle after the second consecutive step BUSY rising edge with no further reversal.
- R8: A step strobe that arrives while a step is in progress is held in a one-entry slot and applied after BUSY falls. A strobe that arrives while the slot is full is dropped.
- R9: Up and down strobes asserted in the same cycle cancel. No BUSY pulse follows and the count does not change.
- R10: The latch-hold input does not change the count, the direction or the ripple clock. Steps taken while it is high still count. Its release (high to low) produces one BUSY pulse with no change of count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_up_i | input | 1 | One-cycle strobe: one LSB of upward movement |
| step_dn_i | input | 1 | One-cycle strobe: one LSB of downward movement |
| hold_i | input | 1 | Latch-hold request from the output side; release asks for a refresh pulse |
| count_o | output | CNT_W | Current up/down count |
| busy_o | output | 1 | Stretched pulse for each count update or refresh |
| dir_o | output | 1 | Direction of the last applied step, 1 = up |
| ripple_o | output | 1 | Ripple clock, raised on each wrap of the count |

## Verification
The bench builds the block with CNT_W = 10, the smallest supported width, and BUSY_CYC = 8 and RC_MIN_CYC = 5. The narrow count lets one scenario step through all 1024 codes and confirm that the count returns to its start with exactly one ripple rising edge. Starting at zero, a single down step reaches the wrap point directly. The short pulse lengths keep the wrap, reversal, deferral, queueing and refresh scenarios to a few dozen cycles each, while still leaving the ripple minimum shorter than BUSY.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    typedef enum logic [1:0] {
        REQ_UP  = 2'd0,
        REQ_DN  = 2'd1,
        REQ_REF = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_RIPL   = 2'd1,
        SEQ_COMMIT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/tsg_req_queue.sv
module tsg_req_queue
    import tsg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up_i,
    input  logic      dn_i,
    input  logic      hold_i,
    input  logic      take_i,
    output logic      req_vld_o,
    output req_kind_e req_kind_o
);

    typedef struct packed {
        logic slot_vld;
        logic slot_up;
        logic ref_pend;
        logic hold;
    } queue_t;

    queue_t q, d;
    logic   new_step;
    logic   take_step;
    logic   take_ref;

    always_comb begin
        d         = q;
        d.hold    = hold_i;
        // opposing strobes in one cycle cancel (R9)
        new_step  = up_i ^ dn_i;
        take_step = take_i && q.slot_vld;
        take_ref  = take_i && !q.slot_vld && q.ref_pend;
        if (take_step) d.slot_vld = 1'b0;
        if (take_ref)  d.ref_pend = 1'b0;
        // single entry: a strobe finding the slot occupied is lost (R8)
        if (new_step && (!q.slot_vld || take_step)) begin
            d.slot_vld = 1'b1;
            d.slot_up  = up_i;
        end
        if (q.hold && !hold_i) d.ref_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_vld_o  = q.slot_vld || q.ref_pend;
    assign req_kind_o = q.slot_vld ? (q.slot_up ? REQ_UP : REQ_DN) : REQ_REF;

endmodule

// File: rtl/tsg_busy_gen.sv
module tsg_busy_gen #(
    parameter int BUSY_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] left;
    } busy_t;

    busy_t q, d;

    always_comb begin
        d = q;
        if (start_i) begin
            d.busy = 1'b1;
            d.left = CW'(BUSY_CYC - 1);
        end else if (q.busy) begin
            if (q.left == '0) d.busy = 1'b0;
            else              d.left = q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;

endmodule

// File: rtl/tsg_ripple_ctrl.sv
module tsg_ripple_ctrl #(
    parameter int RC_MIN_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic dir_chg_i,
    input  logic wrap_i,
    input  logic brise_i,
    output logic rc_o
);

    localparam int TW = $clog2(RC_MIN_CYC + 1);

    typedef struct packed {
        logic          rc;
        logic [TW-1:0] tmr;
        logic          defer;
        logic [1:0]    stab;
    } rc_t;

    rc_t  q, d;
    logic min_ok;
    logic release_ok;

    always_comb begin
        d      = q;
        min_ok = (q.tmr == TW'(RC_MIN_CYC - 1));
        if (q.rc && !min_ok) d.tmr = q.tmr + 1'b1;
        // reversal while high arms the deferral (R7)
        if (dir_chg_i && q.rc) begin
            d.defer = 1'b1;
            d.stab  = 2'd0;
        end else if (brise_i && q.defer && (q.stab != 2'd2)) begin
            d.stab = q.stab + 1'b1;
        end
        release_ok = q.defer ? (q.stab == 2'd2) : take_i;
        if (q.rc && min_ok && !dir_chg_i && release_ok) begin
            d.rc    = 1'b0;
            d.tmr   = '0;
            d.defer = 1'b0;
            d.stab  = 2'd0;
        end
        if (wrap_i) begin
            if (!q.rc) begin
                d.defer = 1'b0;
                d.stab  = 2'd0;
            end
            d.rc  = 1'b1;
            d.tmr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rc_o = q.rc;

endmodule

// File: rtl/track_status_gen.sv
module track_status_gen
    import tsg_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int BUSY_CYC   = 40,
    parameter int RC_MIN_CYC = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up_i,
    input  logic             step_dn_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] count_o,
    output logic             busy_o,
    output logic             dir_o,
    output logic             ripple_o
);

    typedef struct packed {
        seq_state_e       state;
        req_kind_e        kind;
        logic             dir;
        logic [CNT_W-1:0] count;
    } seq_t;

    seq_t      q, d;
    logic      req_vld;
    req_kind_e req_kind;
    logic      take;
    logic      step_take;
    logic      dir_chg;
    logic      wrap;
    logic      start;
    logic      brise;
    logic      busy;

    tsg_req_queue u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_i       (step_up_i),
        .dn_i       (step_dn_i),
        .hold_i     (hold_i),
        .take_i     (take),
        .req_vld_o  (req_vld),
        .req_kind_o (req_kind)
    );

    always_comb begin
        d         = q;
        take      = (q.state == SEQ_IDLE) && !busy && req_vld;
        step_take = take && (req_kind != REQ_REF);
        dir_chg   = step_take && ((req_kind == REQ_UP) != q.dir);
        wrap      = 1'b0;
        start     = 1'b0;
        unique case (q.state)
            SEQ_IDLE: begin
                if (take) begin
                    d.kind  = req_kind;
                    d.state = SEQ_RIPL;
                    if (step_take) d.dir = (req_kind == REQ_UP);
                end
            end
            SEQ_RIPL: begin
                wrap    = ((q.kind == REQ_UP) && (&q.count)) ||
                          ((q.kind == REQ_DN) && (q.count == '0));
                d.state = SEQ_COMMIT;
            end
            SEQ_COMMIT: begin
                start   = 1'b1;
                d.state = SEQ_IDLE;
                if (q.kind == REQ_UP)      d.count = q.count + CNT_W'(1);
                else if (q.kind == REQ_DN) d.count = q.count - CNT_W'(1);
            end
            default: d.state = SEQ_IDLE;
        endcase
        brise = start && (q.kind != REQ_REF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= SEQ_IDLE;
            q.kind  <= REQ_REF;
            q.dir   <= 1'b1;
            q.count <= '0;
        end else begin
            q <= d;
        end
    end

    tsg_busy_gen #(
        .BUSY_CYC (BUSY_CYC)
    ) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy)
    );

    tsg_ripple_ctrl #(
        .RC_MIN_CYC (RC_MIN_CYC)
    ) u_ripple (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (step_take),
        .dir_chg_i (dir_chg),
        .wrap_i    (wrap),
        .brise_i   (brise),
        .rc_o      (ripple_o)
    );

    assign count_o = q.count;
    assign busy_o  = busy;
    assign dir_o   = q.dir;

endmodule

// File: rtl/tsg_chk.sv
module tsg_chk #(
    parameter int CNT_W      = 12,
    parameter int BUSY_CYC   = 40,
    parameter int RC_MIN_CYC = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_o,
    input logic             busy_o,
    input logic             dir_o,
    input logic             ripple_o
);

    logic [15:0] hi_len;
    logic [15:0] rc_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len <= '0;
            rc_len <= '0;
        end else begin
            hi_len <= busy_o   ? ((&hi_len) ? hi_len : hi_len + 1'b1) : '0;
            rc_len <= ripple_o ? ((&rc_len) ? rc_len : rc_len + 1'b1) : '0;
        end
    end

    // R2
    count_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_o) |-> $rose(busy_o));

    // R2
    count_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_o) |-> ((count_o == $past(count_o) + CNT_W'(1)) ||
                               (count_o == $past(count_o) - CNT_W'(1))));

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (hi_len == 16'(BUSY_CYC)));

    // R4
    dir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_o) |-> !busy_o);

    // R4
    dir_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_o) |=> !busy_o);

    // R5
    ripple_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ripple_o) |=> $rose(busy_o));

    // R6
    ripple_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ripple_o) |-> (rc_len >= 16'(RC_MIN_CYC)));

endmodule

bind track_status_gen tsg_chk #(
    .CNT_W      (CNT_W),
    .BUSY_CYC   (BUSY_CYC),
    .RC_MIN_CYC (RC_MIN_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_o  (count_o),
    .busy_o   (busy_o),
    .dir_o    (dir_o),
    .ripple_o (ripple_o)
);

// File: tb/tb_track_status_gen.sv
module tb_track_status_gen;

    localparam int N  = 10;
    localparam int BC = 8;
    localparam int RM = 5;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         up    = 1'b0;
    logic         dn    = 1'b0;
    logic         hold  = 1'b0;
    logic [N-1:0] count;
    logic         busy;
    logic         dir;
    logic         rip;

    int total  = 0;
    int bad    = 0;
    int brises = 0;
    int rrises = 0;
    logic pb = 1'b0;
    logic pr = 1'b0;

    track_status_gen #(
        .CNT_W      (N),
        .BUSY_CYC   (BC),
        .RC_MIN_CYC (RM)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_up_i (up),
        .step_dn_i (dn),
        .hold_i    (hold),
        .count_o   (count),
        .busy_o    (busy),
        .dir_o     (dir),
        .ripple_o  (rip)
    );

    always #4 clk = ~clk;

    // edge counters, sampled just after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (busy && !pb) brises++;
            if (rip && !pr)  rrises++;
        end
        pb = busy;
        pr = rip;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic u, input logic d);
        @(negedge clk); up = u; dn = d;
        @(negedge clk); up = 1'b0; dn = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 count", int'(count), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ripple", int'(rip), 0);
        chk("R1 dir", int'(dir), 1);
    endtask

    task automatic t_down_wrap;
        int w = 0;
        strobe(1'b0, 1'b1);
        cyc(1);
        chk("R4 dir at e+1", int'(dir), 0);
        chk("R4 busy low at e+1", int'(busy), 0);
        cyc(1);
        chk("R5 ripple at e+2", int'(rip), 1);
        chk("R5 busy low at e+2", int'(busy), 0);
        chk("R2 count held at e+2", int'(count), 0);
        cyc(1);
        chk("R2 busy at e+3", int'(busy), 1);
        chk("R2 count down-wrap", int'(count), 1023);
        while (busy && w < 100) begin
            w++;
            @(negedge clk);
        end
        chk("R3 busy width", w, BC);
        cyc(6);
        chk("R6 ripple held until next step", int'(rip), 1);
    endtask

    task automatic t_same_dir_clear;
        strobe(1'b0, 1'b1);
        cyc(1);
        chk("R6 ripple falls at take", int'(rip), 0);
        cyc(2);
        chk("R2 count down", int'(count), 1022);
        cyc(BC + 4);
    endtask

    task automatic t_up_wrap;
        strobe(1'b1, 1'b0);
        cyc(1);
        chk("R4 dir up at e+1", int'(dir), 1);
        cyc(BC + 4);
        chk("R2 count up", int'(count), 1023);
        strobe(1'b1, 1'b0);
        cyc(2);
        chk("R5 ripple on up-wrap", int'(rip), 1);
        cyc(1);
        chk("R2 count up-wrap", int'(count), 0);
        cyc(BC + 4);
    endtask

    task automatic t_hold_refresh;
        int b0 = brises;
        hold = 1'b1;
        cyc(3);
        hold = 1'b0;
        cyc(BC + 8);
        chk("R10 refresh pulse", brises - b0, 1);
        chk("R10 count unchanged", int'(count), 0);
        chk("R10 dir unchanged", int'(dir), 1);
        chk("R10 ripple unchanged", int'(rip), 1);
    endtask

    task automatic t_defer;
        strobe(1'b0, 1'b1);
        cyc(1);
        chk("R7 ripple kept on reversal", int'(rip), 1);
        cyc(BC + 6);
        chk("R2 count after reversal", int'(count), 1023);
        strobe(1'b0, 1'b1);
        cyc(1);
        chk("R7 ripple kept at next take", int'(rip), 1);
        cyc(2);
        chk("R7 ripple high at 2nd busy rise", int'(rip), 1);
        chk("R7 busy at 2nd rise", int'(busy), 1);
        cyc(1);
        chk("R7 ripple falls after 2nd rise", int'(rip), 0);
        chk("R2 count after defer", int'(count), 1022);
        cyc(BC + 4);
    endtask

    task automatic t_queue;
        int b0 = brises;
        strobe(1'b1, 1'b0);
        cyc(4);
        chk("R8 busy in flight", int'(busy), 1);
        strobe(1'b0, 1'b1);
        strobe(1'b1, 1'b0);
        cyc(3 * BC + 20);
        chk("R8 pulses for kept steps", brises - b0, 2);
        chk("R8 count, third dropped", int'(count), 1022);
        chk("R8 dir of queued step", int'(dir), 0);
    endtask

    task automatic t_both;
        int b0 = brises;
        strobe(1'b1, 1'b1);
        cyc(BC + 8);
        chk("R9 no pulse", brises - b0, 0);
        chk("R9 count unchanged", int'(count), 1022);
    endtask

    task automatic t_hold_step;
        int b0 = brises;
        hold = 1'b1;
        strobe(1'b1, 1'b0);
        cyc(BC + 6);
        chk("R10 step counts under hold", int'(count), 1023);
        hold = 1'b0;
        cyc(BC + 8);
        chk("R10 count after release", int'(count), 1023);
        chk("R10 pulses", brises - b0, 2);
    endtask

    task automatic t_rev;
        int r0 = rrises;
        for (int i = 0; i < (1 << N); i++) begin
            strobe(1'b1, 1'b0);
            cyc(BC + 4);
        end
        chk("R2 full revolution", int'(count), 1023);
        chk("R5 one ripple per revolution", rrises - r0, 1);
    endtask

    initial begin
        #(200000 * 8);
        total++;
        bad++;
        $display("FAIL watchdog R1 act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_down_wrap();
        t_same_dir_clear();
        t_up_wrap();
        t_hold_refresh();
        t_defer();
        t_queue();
        t_both();
        t_hold_step();
        t_rev();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule